// File: doc/BRIEF.md
# General-Call Recognizer for a Byte-Level I2C Target

This block sits behind a byte-level I2C target receiver. The receiver has already deserialised the bus traffic, and this block sees it as start and stop strobes and a strobe for each received byte. For every accepted byte the block decides whether it should be acknowledged. It looks for the broadcast write address (0x00 with the direction bit clear) as the first byte of a transfer. When that address is enabled and acknowledged, the block classifies the byte that follows.

A following byte of 0x06 requests a reset of the target interface. A byte of 0x04 asks software to program a new address. A byte equal to a programmable alternate identifier marks a hardware broadcast, in which a device announces its own address. Any other byte is still recorded as a broadcast. The result is held in a sticky status flag and a 2-bit code until software pulses a clear input. An interrupt output follows the sticky flag.

Top module: `gcall_recognizer`

## Requirements
- R1: While reset is high, and in the cycle after it is released, ack_vld, ack, soft_rst, gc_stat, gc_id and irq are all 0.
- R2: With slave_en and gcall_en high, a byte of 0x00 taken as the first byte after a start gives ack_vld=1 and ack=1 in the cycle after its strobe. A first byte of any other value, including 0x01 (read direction), gives ack_vld=1 with ack=0.
- R3: With gcall_en low, a first byte of 0x00 gives ack=0, and the byte after it changes neither gc_stat nor gc_id.
- R4: After an acknowledged broadcast address, a byte of 0x06 sets gc_stat with gc_id=01 and raises soft_rst for exactly one cycle, in the cycle after its strobe. The sequencer then waits for an address byte again, so a following 0x00 is acknowledged as a fresh broadcast address.
- R5: After an acknowledged broadcast address, a byte of 0x04 sets gc_stat with gc_id=10 and gives no soft_rst.
- R6: With hwcall_en and gcall_en both high, a byte after the broadcast address that equals alt_id in all 8 bits sets gc_id=11. With hwcall_en low, the same byte gives gc_id=00. The 0x06 and 0x04 codes take priority over an alt_id match.
- R7: Any other byte after an acknowledged broadcast address sets gc_stat with gc_id=00. Every byte that follows an acknowledged broadcast address is itself acknowledged.
- R8: A one-cycle stat_clr pulse clears gc_stat and gc_id from the next cycle onward. If a classified byte arrives in the same cycle as the clear, the new result is kept.
- R9: irq is high exactly while gc_stat is high, so it falls in the cycle after a clear pulse.
- R10: With slave_en low, no byte is acknowledged, soft_rst stays 0 and gc_stat and gc_id do not change.
- R11: A start or stop strobe returns the sequencer to waiting for an address byte. A repeated start after an acknowledged broadcast address discards the pending classification, and the next byte is judged as an address.
- R12: A byte strobe in the same cycle as a start or stop is ignored and gives ack_vld=0. Bytes after a non-broadcast address, or after the classified byte, give ack=0 and change no status until the next start or stop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_stb | input | 1 | Start or repeated-start seen on the bus |
| stop_stb | input | 1 | Stop seen on the bus |
| byte_stb | input | 1 | A received byte is valid on byte_data |
| byte_data | input | 8 | Received byte |
| slave_en | input | 1 | Master enable for all recognition |
| gcall_en | input | 1 | Enable acknowledging the broadcast address |
| hwcall_en | input | 1 | Enable matching against alt_id |
| alt_id | input | 8 | Alternate identifier for hardware broadcasts |
| stat_clr | input | 1 | One-cycle pulse that clears status and code |
| ack_vld | output | 1 | An ack decision is presented this cycle |
| ack | output | 1 | Decision: 1 acknowledge, 0 not |
| soft_rst | output | 1 | One-cycle reset request for the target interface |
| gc_stat | output | 1 | Sticky broadcast-received flag |
| gc_id | output | 2 | 00 other, 01 reset, 10 program address, 11 hardware match |
| irq | output | 1 | Interrupt, high while gc_stat is set |

## Verification
The case that is hardest to reach from the ports is a clear pulse in the same cycle as a classified byte. Two further cases are hard to reach: a start that lands between the broadcast address and its data byte, and an alt_id equal to one of the command codes. Each needs a strobe aligned to a precise cycle within a multi-byte sequence. The bench drives each of these cases with tasks that step one cycle at a time. A behavioural model follows the transfer position and the sticky state, and its expected ack, reset pulse, status and code are compared with the outputs after every clock.

// File: rtl/gcr_pkg.sv
package gcr_pkg;

    localparam int unsigned BYTE_W = 8;
    localparam int unsigned GID_W  = 2;

    localparam logic [BYTE_W-1:0] ADDR_BCAST_WR = 8'h00;
    localparam logic [BYTE_W-1:0] CMD_RESET     = 8'h06;
    localparam logic [BYTE_W-1:0] CMD_PROG      = 8'h04;

    typedef enum logic [1:0] {
        SEQ_ADDR   = 2'd0,
        SEQ_GCDATA = 2'd1,
        SEQ_SKIP   = 2'd2
    } seq_t;

    typedef enum logic [GID_W-1:0] {
        GID_NONE  = 2'b00,
        GID_RESET = 2'b01,
        GID_PROG  = 2'b10,
        GID_HW    = 2'b11
    } gid_t;

    typedef struct packed {
        logic vld;
        gid_t id;
        logic reset_cmd;
    } gc_evt_t;

    function automatic gid_t classify(input logic [BYTE_W-1:0] b,
                                      input logic              hw_ok,
                                      input logic [BYTE_W-1:0] alt);
        gid_t r;
        if (b == CMD_RESET)           r = GID_RESET;
        else if (b == CMD_PROG)       r = GID_PROG;
        else if (hw_ok && (b == alt)) r = GID_HW;
        else                          r = GID_NONE;
        return r;
    endfunction

endpackage

// File: rtl/gcr_seq.sv
module gcr_seq
    import gcr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start_stb,
    input  logic              stop_stb,
    input  logic              byte_stb,
    input  logic [BYTE_W-1:0] byte_data,
    input  logic              slave_en,
    input  logic              gcall_en,
    input  logic              hwcall_en,
    input  logic [BYTE_W-1:0] alt_id,
    output logic              ack_vld,
    output logic              ack,
    output logic              soft_rst,
    output gc_evt_t           evt
);

    seq_t st;
    logic take;

    assign take = byte_stb & ~start_stb & ~stop_stb;

    always_comb begin
        evt.vld       = take & slave_en & (st == SEQ_GCDATA);
        evt.id        = classify(byte_data, hwcall_en & gcall_en, alt_id);
        evt.reset_cmd = (byte_data == CMD_RESET);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st       <= SEQ_ADDR;
            ack_vld  <= 1'b0;
            ack      <= 1'b0;
            soft_rst <= 1'b0;
        end else begin
            ack_vld  <= take;
            ack      <= 1'b0;
            soft_rst <= 1'b0;
            if (start_stb || stop_stb || !slave_en) begin
                st <= SEQ_ADDR;
            end else if (take) begin
                case (st)
                    SEQ_ADDR: begin
                        if (byte_data == ADDR_BCAST_WR && gcall_en) begin
                            ack <= 1'b1;
                            st  <= SEQ_GCDATA;
                        end else begin
                            st  <= SEQ_SKIP;
                        end
                    end
                    SEQ_GCDATA: begin
                        ack <= 1'b1;
                        if (evt.reset_cmd) begin
                            soft_rst <= 1'b1;
                            st       <= SEQ_ADDR;
                        end else begin
                            st       <= SEQ_SKIP;
                        end
                    end
                    default: st <= SEQ_SKIP;
                endcase
            end
        end
    end

    // R4: reset request lasts one cycle
    a_r4_srst_pulse: assert property (@(posedge clk) disable iff (rst)
        soft_rst |=> !soft_rst);

    // R4: reset request only follows a received 0x06
    a_r4_srst_cause: assert property (@(posedge clk) disable iff (rst)
        soft_rst |-> ($past(byte_stb) && $past(byte_data) == CMD_RESET));

    // R10: no acknowledge unless the target was enabled
    a_r10_ack_needs_en: assert property (@(posedge clk) disable iff (rst)
        ack |-> $past(slave_en));

endmodule

// File: rtl/gcr_status.sv
module gcr_status
    import gcr_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  gc_evt_t evt,
    input  logic    stat_clr,
    output logic    gc_stat,
    output gid_t    gc_id,
    output logic    irq
);

    always_ff @(posedge clk) begin
        if (rst) begin
            gc_stat <= 1'b0;
            gc_id   <= GID_NONE;
        end else if (evt.vld) begin
            gc_stat <= 1'b1;
            gc_id   <= evt.id;
        end else if (stat_clr) begin
            gc_stat <= 1'b0;
            gc_id   <= GID_NONE;
        end
    end

    assign irq = gc_stat;

    // R8: clear without a new event empties status and code
    a_r8_clear: assert property (@(posedge clk) disable iff (rst)
        (stat_clr && !evt.vld) |=> (!gc_stat && gc_id == GID_NONE));

    // R8: status is sticky while nothing touches it
    a_r8_sticky: assert property (@(posedge clk) disable iff (rst)
        (!evt.vld && !stat_clr) |=> ($stable(gc_stat) && $stable(gc_id)));

    // R7: status only rises on a classified byte
    a_r7_rise_cause: assert property (@(posedge clk) disable iff (rst)
        $rose(gc_stat) |-> $past(evt.vld));

endmodule

// File: rtl/gcall_recognizer.sv
module gcall_recognizer
    import gcr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start_stb,
    input  logic              stop_stb,
    input  logic              byte_stb,
    input  logic [BYTE_W-1:0] byte_data,
    input  logic              slave_en,
    input  logic              gcall_en,
    input  logic              hwcall_en,
    input  logic [BYTE_W-1:0] alt_id,
    input  logic              stat_clr,
    output logic              ack_vld,
    output logic              ack,
    output logic              soft_rst,
    output logic              gc_stat,
    output logic [GID_W-1:0]  gc_id,
    output logic              irq
);

    gc_evt_t evt;
    gid_t    id_q;

    gcr_seq u_seq (
        .clk       (clk),
        .rst       (rst),
        .start_stb (start_stb),
        .stop_stb  (stop_stb),
        .byte_stb  (byte_stb),
        .byte_data (byte_data),
        .slave_en  (slave_en),
        .gcall_en  (gcall_en),
        .hwcall_en (hwcall_en),
        .alt_id    (alt_id),
        .ack_vld   (ack_vld),
        .ack       (ack),
        .soft_rst  (soft_rst),
        .evt       (evt)
    );

    gcr_status u_status (
        .clk      (clk),
        .rst      (rst),
        .evt      (evt),
        .stat_clr (stat_clr),
        .gc_stat  (gc_stat),
        .gc_id    (id_q),
        .irq      (irq)
    );

    assign gc_id = id_q;

    // R12: a decision is only driven alongside its valid flag
    a_r12_ack_qualified: assert property (@(posedge clk) disable iff (rst)
        ack |-> ack_vld);

    // R4: a reset request is always reported in the status
    a_r4_srst_status: assert property (@(posedge clk) disable iff (rst)
        soft_rst |-> (gc_stat && gc_id == 2'b01));

endmodule

// File: tb/gcall_recognizer_test.sv
module gcall_recognizer_test;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       start_stb = 1'b0, stop_stb = 1'b0, byte_stb = 1'b0;
    logic [7:0] byte_data = 8'h00;
    logic       slave_en = 1'b0, gcall_en = 1'b0, hwcall_en = 1'b0;
    logic [7:0] alt_id = 8'h00;
    logic       stat_clr = 1'b0;
    logic       ack_vld, ack, soft_rst, gc_stat, irq;
    logic [1:0] gc_id;

    int n_chk = 0;
    int n_bad = 0;
    string cur_req = "R1";

    // behavioural reference state
    int m_pos = 0;   // 0 expect address, 1 expect command byte, 2 ignore
    int m_av = 0, m_a = 0, m_sr = 0, m_st = 0, m_id = 0;

    always #5 clk = ~clk;

    gcall_recognizer uut (
        .clk(clk), .rst(rst), .start_stb(start_stb), .stop_stb(stop_stb),
        .byte_stb(byte_stb), .byte_data(byte_data), .slave_en(slave_en),
        .gcall_en(gcall_en), .hwcall_en(hwcall_en), .alt_id(alt_id),
        .stat_clr(stat_clr), .ack_vld(ack_vld), .ack(ack), .soft_rst(soft_rst),
        .gc_stat(gc_stat), .gc_id(gc_id), .irq(irq)
    );

    task automatic chk(input int act, input int exp, input string what);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", cur_req, what, act, exp);
        end
    endtask

    task automatic model_step();
        int nid;
        bit ev;
        bit taken;
        ev = 0; nid = 0;
        taken = byte_stb && !start_stb && !stop_stb;
        if (rst) begin
            m_pos = 0; m_av = 0; m_a = 0; m_sr = 0; m_st = 0; m_id = 0;
            return;
        end
        m_av = taken; m_a = 0; m_sr = 0;
        if (start_stb || stop_stb || !slave_en) begin
            m_pos = 0;
        end else if (taken) begin
            if (m_pos == 0) begin
                if (byte_data == 8'h00 && gcall_en) begin m_a = 1; m_pos = 1; end
                else m_pos = 2;
            end else if (m_pos == 1) begin
                m_a = 1; ev = 1;
                if (byte_data == 8'h06) nid = 1;
                else if (byte_data == 8'h04) nid = 2;
                else if (hwcall_en && gcall_en && byte_data == alt_id) nid = 3;
                else nid = 0;
                if (byte_data == 8'h06) begin m_sr = 1; m_pos = 0; end
                else m_pos = 2;
            end
        end
        if (ev) begin m_st = 1; m_id = nid; end
        else if (stat_clr) begin m_st = 0; m_id = 0; end
    endtask

    task automatic tick();
        model_step();
        @(posedge clk);
        #1;
        chk(ack_vld, m_av, "ack_vld");
        chk(ack, m_a, "ack");
        chk(soft_rst, m_sr, "soft_rst");
        chk(gc_stat, m_st, "gc_stat");
        chk(gc_id, m_id, "gc_id");
        chk(irq, m_st, "irq");
    endtask

    task automatic do_start();
        start_stb = 1'b1; tick(); start_stb = 1'b0; tick();
    endtask

    task automatic do_stop();
        stop_stb = 1'b1; tick(); stop_stb = 1'b0; tick();
    endtask

    task automatic send(input logic [7:0] b);
        byte_data = b; byte_stb = 1'b1; tick(); byte_stb = 1'b0; tick();
    endtask

    task automatic do_clear();
        stat_clr = 1'b1; tick(); stat_clr = 1'b0; tick();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        #1;
        cur_req = "R1";
        repeat (3) tick();
        rst = 1'b0;
        tick();
        slave_en = 1'b1; gcall_en = 1'b1;
        tick();

        cur_req = "R2";
        do_start(); send(8'h00);
        cur_req = "R7";
        send(8'h55);
        cur_req = "R12";
        send(8'h04);
        do_stop();
        cur_req = "R2";
        do_start(); send(8'h01);
        cur_req = "R12";
        send(8'h04); do_stop();

        cur_req = "R9";
        do_clear();
        cur_req = "R5";
        do_start(); send(8'h00); send(8'h04); do_stop();
        cur_req = "R9";
        do_clear();

        cur_req = "R8";
        do_start(); send(8'h00);
        byte_data = 8'h06; byte_stb = 1'b1; stat_clr = 1'b1; tick();
        byte_stb = 1'b0; stat_clr = 1'b0; tick();
        cur_req = "R4";
        send(8'h00); send(8'h04); do_stop();
        do_clear();
        do_start(); send(8'h00); send(8'h06); tick(); do_stop();

        cur_req = "R6";
        do_clear();
        hwcall_en = 1'b1; alt_id = 8'h35;
        do_start(); send(8'h00); send(8'h35); do_stop();
        do_clear();
        hwcall_en = 1'b0;
        do_start(); send(8'h00); send(8'h35); do_stop();
        hwcall_en = 1'b1; alt_id = 8'h06;
        do_start(); send(8'h00); send(8'h06); do_stop();
        alt_id = 8'h04;
        do_start(); send(8'h00); send(8'h04); do_stop();
        hwcall_en = 1'b0;

        cur_req = "R3";
        do_clear();
        gcall_en = 1'b0;
        do_start(); send(8'h00); send(8'h04); do_stop();
        gcall_en = 1'b1;

        cur_req = "R10";
        slave_en = 1'b0;
        do_start(); send(8'h00); send(8'h06); do_stop();
        slave_en = 1'b1;
        do_start(); send(8'h00); send(8'h04); do_stop();
        slave_en = 1'b0;
        do_start(); send(8'h00); send(8'h55); do_stop();
        slave_en = 1'b1;
        do_clear();

        cur_req = "R11";
        do_start(); send(8'h00); do_start(); send(8'h04); do_stop();
        do_start(); send(8'h00); do_stop(); send(8'h00); send(8'h06); tick();
        do_clear();

        cur_req = "R12";
        do_start();
        byte_data = 8'h00; byte_stb = 1'b1; start_stb = 1'b1; tick();
        byte_stb = 1'b0; start_stb = 1'b0; tick();
        send(8'h00);
        byte_data = 8'h04; byte_stb = 1'b1; stop_stb = 1'b1; tick();
        byte_stb = 1'b0; stop_stb = 1'b0; tick();
        send(8'h04);
        repeat (3) tick();

        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule